// File: doc/BRIEF.md
# MSI Blocking L1 Cache Controller

This block is a small, blocking, direct-mapped L1 data cache that acts as one child in a two-level MSI directory coherence system. A processor sends loads and stores. Load data comes back on a response channel. Every line holds one data word, an address tag and a permission level. The permission level is invalid (I), shared and read-only (S), or modified, exclusive and writable (M), and the levels are ordered M > S > I.

The cache talks to its parent over two message queues. The outgoing queue carries fill requests and write-back or downgrade responses. The incoming queue carries fill responses and downgrade requests. On a tag miss the cache first evicts the slot's current line, with a write-back if that line is dirty, and then asks for the line. A store that hits a read-only line skips the eviction and asks for write permission only. Only one miss is handled at a time.

Downgrade requests from the parent are served whenever the cache is not returning fill data to the processor. This includes the time while the cache waits for its own fill, so a downgrade can overtake, or arrive after, an eviction of the same line.

Top module: `msi_l1_cache`

## Requirements
- R1: After reset every line is invalid and the cache is idle. The processor request channel is ready, and neither outgoing channel holds a message.
- R2: A load that hits a line in S or M puts that line's data on the processor response channel at the clock edge that accepts the load. It sends no message to the parent.
- R3: A store that hits a line in M overwrites the line's data and sends no message to the parent.
- R4: A store that hits a line in S sends no eviction. It sends one request for level M (code 2) for that address. Once the fill response arrives, the line holds the store data and not the returned data.
- R5: A miss whose slot is invalid sends exactly one request to the parent: level S (code 1) for a load, level M (code 2) for a store. The request carries no data.
- R6: A miss whose slot holds another valid line first sends a response for the old address with level I (code 0). Data is attached (data flag 1) only if the old line was in M. The fill request follows it.
- R7: A fill response records the level it grants and the requested tag. A load miss returns the data from the fill, and a line granted M takes later stores without traffic.
- R8: A downgrade request to a level below the line's current level is answered with a response that carries that level and the line's address. Data is attached only if the line was in M, and the line drops to that level.
- R9: A downgrade request to a level at or above the line's current level, or for an address whose tag is not stored, is consumed and produces no message.
- R10: When a downgrade request and a processor request are present together, the downgrade is served first and the processor request waits. No downgrade request is accepted in the cycle in which a load miss hands its data back.
- R11: While a miss is outstanding the processor request channel is not ready.
- R12: A message on the outgoing parent channel or the processor response channel holds its valid and its contents until it is accepted. While a processor response waits, no new processor request is accepted.

Message encodings: cmd bit 1 is a response and 0 is a request. The level codes are I=0, S=1 and M=2. In an address, the low log2(SLOTS) bits are the slot index and the rest is the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procReqValid | input | 1 | Processor request valid |
| procReqReady | output | 1 | Processor request accepted this cycle |
| procReqIsStore | input | 1 | 1 = store, 0 = load |
| procReqAddr | input | ADDR_W | Word address |
| procReqData | input | DATA_W | Store data |
| procRespValid | output | 1 | Load data valid |
| procRespReady | input | 1 | Processor takes load data |
| procRespData | output | DATA_W | Load data |
| c2pValid | output | 1 | Outgoing parent message valid |
| c2pReady | input | 1 | Parent takes the message |
| c2pIsResp | output | 1 | 1 = response, 0 = request |
| c2pAddr | output | ADDR_W | Message address |
| c2pState | output | 2 | Requested or resulting level |
| c2pHasData | output | 1 | Data field carries a dirty line |
| c2pData | output | DATA_W | Write-back data (0 when absent) |
| p2cValid | input | 1 | Incoming parent message valid |
| p2cReady | output | 1 | Cache consumes the message |
| p2cIsResp | input | 1 | 1 = fill response, 0 = downgrade request |
| p2cAddr | input | ADDR_W | Message address |
| p2cState | input | 2 | Granted level or downgrade target |
| p2cData | input | DATA_W | Fill data |

## Verification
Two functions can collide in one cycle. The first pair is a downgrade request from the parent and a new processor request to the same line. The bench raises both valids at the same clock. It requires the incoming queue to be ready and the processor channel not ready. It then requires the downgrade reply to come before the processor's own miss request, with the line's dirty data in that reply. The second pair is a fill response followed at once by a downgrade. The bench requires that the downgrade is refused in the cycle the load data is handed back and accepted in the next one.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineState_e;

  typedef enum logic [2:0] {
    PH_READY      = 3'd0,
    PH_START_MISS = 3'd1,
    PH_SEND_FILL  = 3'd2,
    PH_WAIT_FILL  = 3'd3,
    PH_RESP       = 3'd4
  } missPhase_e;

  // control -> datapath, at most one action per cycle
  typedef struct packed {
    logic latchMiss;
    logic loadHit;
    logic storeWrite;
    logic dnReply;
    logic evict;
    logic sendFill;
    logic fillWrite;
    logic respLoad;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       procHit;
    lineState_e procState;
    logic       dnAbove;
    lineState_e victimState;
    logic       missIsStore;
    logic       c2pBusy;
    logic       respBusy;
  } dpStatus_t;

endpackage

// File: rtl/msi_l1_datapath.sv
module msi_l1_datapath
  import msi_l1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  input  logic              procReqIsStore,
  input  logic [ADDR_W-1:0] procReqAddr,
  input  logic [DATA_W-1:0] procReqData,
  input  logic              procRespReady,
  output logic              procRespValid,
  output logic [DATA_W-1:0] procRespData,
  input  logic              c2pReady,
  output logic              c2pValid,
  output logic              c2pIsResp,
  output logic [ADDR_W-1:0] c2pAddr,
  output logic [1:0]        c2pState,
  output logic              c2pHasData,
  output logic [DATA_W-1:0] c2pData,
  input  logic [ADDR_W-1:0] p2cAddr,
  input  logic [1:0]        p2cState,
  input  logic [DATA_W-1:0] p2cData
);

  localparam int INDEX_W = $clog2(SLOTS);
  localparam int TAG_W   = ADDR_W - INDEX_W;

  lineState_e        stateArr [SLOTS];
  logic [TAG_W-1:0]  tagArr   [SLOTS];
  logic [DATA_W-1:0] dataArr  [SLOTS];

  logic [ADDR_W-1:0] missAddr;
  logic              missIsStore;
  logic [DATA_W-1:0] missData;

  logic [INDEX_W-1:0] procIdx, dnIdx, missIdx;
  logic [TAG_W-1:0]   procTag, dnTag, missTag;
  lineState_e         dnCur, dnTarget, victimState;

  assign procIdx = procReqAddr[INDEX_W-1:0];
  assign procTag = procReqAddr[ADDR_W-1:INDEX_W];
  assign dnIdx   = p2cAddr[INDEX_W-1:0];
  assign dnTag   = p2cAddr[ADDR_W-1:INDEX_W];
  assign missIdx = missAddr[INDEX_W-1:0];
  assign missTag = missAddr[ADDR_W-1:INDEX_W];

  assign dnTarget    = lineState_e'(p2cState);
  assign dnCur       = (tagArr[dnIdx] == dnTag) ? stateArr[dnIdx] : LINE_I;
  assign victimState = stateArr[missIdx];

  always_comb begin
    status.procHit     = (stateArr[procIdx] != LINE_I) && (tagArr[procIdx] == procTag);
    status.procState   = stateArr[procIdx];
    status.dnAbove     = dnCur > dnTarget;
    status.victimState = victimState;
    status.missIsStore = missIsStore;
    status.c2pBusy     = c2pValid;
    status.respBusy    = procRespValid;
  end

  // permission levels (the only array state that needs reset)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) stateArr[i] <= LINE_I;
    end else if (strobe.dnReply) begin
      stateArr[dnIdx] <= dnTarget;
    end else if (strobe.evict) begin
      stateArr[missIdx] <= LINE_I;
    end else if (strobe.fillWrite) begin
      stateArr[missIdx] <= lineState_e'(p2cState);
    end
  end

  // tag and data arrays
  always_ff @(posedge clk) begin
    if (strobe.storeWrite) begin
      dataArr[procIdx] <= procReqData;
    end else if (strobe.fillWrite) begin
      dataArr[missIdx] <= missIsStore ? missData : p2cData;
      tagArr[missIdx]  <= missTag;
    end
  end

  // miss register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      missAddr    <= '0;
      missIsStore <= 1'b0;
      missData    <= '0;
    end else if (strobe.latchMiss) begin
      missAddr    <= procReqAddr;
      missIsStore <= procReqIsStore;
      missData    <= procReqData;
    end
  end

  // outgoing parent message holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      c2pValid   <= 1'b0;
      c2pIsResp  <= 1'b0;
      c2pAddr    <= '0;
      c2pState   <= 2'd0;
      c2pHasData <= 1'b0;
      c2pData    <= '0;
    end else if (strobe.dnReply) begin
      c2pValid   <= 1'b1;
      c2pIsResp  <= 1'b1;
      c2pAddr    <= p2cAddr;
      c2pState   <= p2cState;
      c2pHasData <= (dnCur == LINE_M);
      c2pData    <= (dnCur == LINE_M) ? dataArr[dnIdx] : '0;
    end else if (strobe.evict) begin
      c2pValid   <= 1'b1;
      c2pIsResp  <= 1'b1;
      c2pAddr    <= {tagArr[missIdx], missIdx};
      c2pState   <= LINE_I;
      c2pHasData <= (victimState == LINE_M);
      c2pData    <= (victimState == LINE_M) ? dataArr[missIdx] : '0;
    end else if (strobe.sendFill) begin
      c2pValid   <= 1'b1;
      c2pIsResp  <= 1'b0;
      c2pAddr    <= missAddr;
      c2pState   <= missIsStore ? LINE_M : LINE_S;
      c2pHasData <= 1'b0;
      c2pData    <= '0;
    end else if (c2pValid && c2pReady) begin
      c2pValid <= 1'b0;
    end
  end

  // processor response holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      procRespValid <= 1'b0;
      procRespData  <= '0;
    end else if (strobe.loadHit) begin
      procRespValid <= 1'b1;
      procRespData  <= dataArr[procIdx];
    end else if (strobe.respLoad) begin
      procRespValid <= 1'b1;
      procRespData  <= dataArr[missIdx];
    end else if (procRespValid && procRespReady) begin
      procRespValid <= 1'b0;
    end
  end

  p_c2p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    c2pValid && !c2pReady |=> c2pValid && $stable(c2pAddr) && $stable(c2pState)
                              && $stable(c2pIsResp) && $stable(c2pData))
    else $error("outgoing parent message changed before acceptance");

  p_resp_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    procRespValid && !procRespReady |=> procRespValid && $stable(procRespData))
    else $error("processor response changed before acceptance");

  p_resp_below_m_r8: assert property (@(posedge clk) disable iff (!rstN)
    c2pValid && c2pIsResp |-> c2pState != LINE_M)
    else $error("response to parent claims level M");

  p_fill_req_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    c2pValid && !c2pIsResp |-> (c2pState != LINE_I) && !c2pHasData)
    else $error("fill request with level I or with data");

  p_evict_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evict |=> c2pHasData == ($past(victimState) == LINE_M))
    else $error("eviction data flag does not match victim level");

endmodule

// File: rtl/msi_l1_control.sv
module msi_l1_control
  import msi_l1_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procReqValid,
  input  logic        procReqIsStore,
  output logic        procReqReady,
  input  logic        p2cValid,
  input  logic        p2cIsResp,
  output logic        p2cReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);

  missPhase_e phase, phaseNext;
  logic dnPending, dnTake, fillTake, procTake;

  assign dnPending    = p2cValid && !p2cIsResp;
  assign dnTake       = dnPending && (phase != PH_RESP) && !status.c2pBusy;
  assign fillTake     = (phase == PH_WAIT_FILL) && p2cValid && p2cIsResp;
  assign procReqReady = (phase == PH_READY) && !dnPending && !status.respBusy;
  assign procTake     = procReqValid && procReqReady;
  assign p2cReady     = dnTake || fillTake;

  always_comb begin
    strobe         = '0;
    phaseNext      = phase;
    strobe.dnReply = dnTake && status.dnAbove;
    unique case (phase)
      PH_READY: begin
        if (procTake) begin
          if (status.procHit && !procReqIsStore) begin
            strobe.loadHit = 1'b1;
          end else if (status.procHit && status.procState == LINE_M) begin
            strobe.storeWrite = 1'b1;
          end else if (status.procHit) begin
            strobe.latchMiss = 1'b1;
            phaseNext        = PH_SEND_FILL;
          end else begin
            strobe.latchMiss = 1'b1;
            phaseNext        = PH_START_MISS;
          end
        end
      end
      PH_START_MISS: begin
        if (!dnTake && !status.c2pBusy) begin
          strobe.evict = (status.victimState != LINE_I);
          phaseNext    = PH_SEND_FILL;
        end
      end
      PH_SEND_FILL: begin
        if (!dnTake && !status.c2pBusy) begin
          strobe.sendFill = 1'b1;
          phaseNext       = PH_WAIT_FILL;
        end
      end
      PH_WAIT_FILL: begin
        if (fillTake) begin
          strobe.fillWrite = 1'b1;
          phaseNext        = PH_RESP;
        end
      end
      PH_RESP: begin
        if (status.missIsStore) begin
          phaseNext = PH_READY;
        end else if (!status.respBusy) begin
          strobe.respLoad = 1'b1;
          phaseNext       = PH_READY;
        end
      end
      default: phaseNext = PH_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_READY;
    else       phase <= phaseNext;
  end

  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe))
    else $error("more than one datapath action in one cycle");

  p_no_dn_in_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RESP) && p2cValid && !p2cIsResp |-> !p2cReady)
    else $error("downgrade accepted while handing back fill data");

  p_fill_then_resp_r7: assert property (@(posedge clk) disable iff (!rstN)
    fillTake |=> phase == PH_RESP)
    else $error("fill response not followed by the hand-back phase");

  p_single_miss_r11: assert property (@(posedge clk) disable iff (!rstN)
    procTake && strobe.latchMiss |=> !procReqReady)
    else $error("new processor request accepted with a miss outstanding");

endmodule

// File: rtl/msi_l1_cache.sv
module msi_l1_cache
  import msi_l1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procReqValid,
  output logic              procReqReady,
  input  logic              procReqIsStore,
  input  logic [ADDR_W-1:0] procReqAddr,
  input  logic [DATA_W-1:0] procReqData,
  output logic              procRespValid,
  input  logic              procRespReady,
  output logic [DATA_W-1:0] procRespData,
  output logic              c2pValid,
  input  logic              c2pReady,
  output logic              c2pIsResp,
  output logic [ADDR_W-1:0] c2pAddr,
  output logic [1:0]        c2pState,
  output logic              c2pHasData,
  output logic [DATA_W-1:0] c2pData,
  input  logic              p2cValid,
  output logic              p2cReady,
  input  logic              p2cIsResp,
  input  logic [ADDR_W-1:0] p2cAddr,
  input  logic [1:0]        p2cState,
  input  logic [DATA_W-1:0] p2cData
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  msi_l1_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .procReqValid   (procReqValid),
    .procReqIsStore (procReqIsStore),
    .procReqReady   (procReqReady),
    .p2cValid       (p2cValid),
    .p2cIsResp      (p2cIsResp),
    .p2cReady       (p2cReady),
    .status         (status),
    .strobe         (strobe)
  );

  msi_l1_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOTS  (SLOTS)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .status         (status),
    .procReqIsStore (procReqIsStore),
    .procReqAddr    (procReqAddr),
    .procReqData    (procReqData),
    .procRespReady  (procRespReady),
    .procRespValid  (procRespValid),
    .procRespData   (procRespData),
    .c2pReady       (c2pReady),
    .c2pValid       (c2pValid),
    .c2pIsResp      (c2pIsResp),
    .c2pAddr        (c2pAddr),
    .c2pState       (c2pState),
    .c2pHasData     (c2pHasData),
    .c2pData        (c2pData),
    .p2cAddr        (p2cAddr),
    .p2cState       (p2cState),
    .p2cData        (p2cData)
  );

endmodule

// File: tb/msi_l1_cache_tb.sv
module msi_l1_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SLOTS  = 8;
  localparam logic [1:0] LV_I = 2'd0, LV_S = 2'd1, LV_M = 2'd2;
  // three tags on slot 3, one address on slot 5
  localparam logic [15:0] ADR_A = 16'h0013, ADR_B = 16'h001B, ADR_C = 16'h0023, ADR_D = 16'h0005;

  logic clk = 1'b0, rstN = 1'b0;
  logic procReqValid = 0, procReqIsStore = 0, procRespReady = 1;
  logic [ADDR_W-1:0] procReqAddr = '0;
  logic [DATA_W-1:0] procReqData = '0;
  logic procReqReady, procRespValid;
  logic [DATA_W-1:0] procRespData;
  logic c2pValid, c2pIsResp, c2pHasData, c2pReady = 1;
  logic [ADDR_W-1:0] c2pAddr;
  logic [1:0] c2pState;
  logic [DATA_W-1:0] c2pData;
  logic p2cValid = 0, p2cIsResp = 0, p2cReady;
  logic [ADDR_W-1:0] p2cAddr = '0;
  logic [1:0] p2cState = '0;
  logic [DATA_W-1:0] p2cData = '0;

  int checks = 0, failures = 0;
  int logN = 0, respN = 0;
  logic [51:0] msgLog [64];
  logic [31:0] respLog [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_l1_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_dut (
    .clk(clk), .rstN(rstN),
    .procReqValid(procReqValid), .procReqReady(procReqReady), .procReqIsStore(procReqIsStore),
    .procReqAddr(procReqAddr), .procReqData(procReqData),
    .procRespValid(procRespValid), .procRespReady(procRespReady), .procRespData(procRespData),
    .c2pValid(c2pValid), .c2pReady(c2pReady), .c2pIsResp(c2pIsResp), .c2pAddr(c2pAddr),
    .c2pState(c2pState), .c2pHasData(c2pHasData), .c2pData(c2pData),
    .p2cValid(p2cValid), .p2cReady(p2cReady), .p2cIsResp(p2cIsResp), .p2cAddr(p2cAddr),
    .p2cState(p2cState), .p2cData(p2cData));

  // message monitors
  always @(posedge clk) begin
    if (rstN && c2pValid && c2pReady && logN < 64) begin
      msgLog[logN] = {c2pIsResp, c2pAddr, c2pState, c2pHasData, c2pData};
      logN++;
    end
    if (rstN && procRespValid && procRespReady && respN < 64) begin
      respLog[respN] = procRespData;
      respN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic procSend(input bit st, input logic [15:0] addr, input logic [31:0] data);
    @(negedge clk);
    procReqValid = 1; procReqIsStore = st; procReqAddr = addr; procReqData = data;
    #1;
    while (!procReqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    procReqValid = 0;
  endtask

  task automatic p2cSend(input bit isResp, input logic [15:0] addr, input logic [1:0] st,
                         input logic [31:0] data);
    @(negedge clk);
    p2cValid = 1; p2cIsResp = isResp; p2cAddr = addr; p2cState = st; p2cData = data;
    #1;
    while (!p2cReady) begin @(negedge clk); #1; end
    @(negedge clk);
    p2cValid = 0;
  endtask

  task automatic waitMsgs(input int n);
    for (int i = 0; i < 40 && logN < n; i++) @(negedge clk);
  endtask

  task automatic waitResps(input int n);
    for (int i = 0; i < 40 && respN < n; i++) @(negedge clk);
  endtask

  task automatic checkMsg(input int k, input bit isResp, input logic [15:0] addr,
                          input logic [1:0] st, input bit hasData, input logic [31:0] data,
                          input string req);
    logic [51:0] exp;
    exp = {isResp, addr, st, hasData, hasData ? data : 32'h0};
    if (logN <= k) check(0, req, "missing parent message", 64'(logN), 64'(k + 1));
    else check(msgLog[k] == exp, req, "parent message", 64'(msgLog[k]), 64'(exp));
  endtask

  task automatic checkLastResp(input logic [31:0] exp, input int n, input string req);
    if (respN < n) check(0, req, "missing load data", 64'(respN), 64'(n));
    else check(respLog[n-1] == exp, req, "load data", 64'(respLog[n-1]), 64'(exp));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(procReqReady == 1, "R1", "request ready after reset", 64'(procReqReady), 1);
    check(c2pValid == 0, "R1", "no parent message after reset", 64'(c2pValid), 0);
    check(procRespValid == 0, "R1", "no load data after reset", 64'(procRespValid), 0);
  endtask

  task automatic t_loadMiss();
    int n0 = logN, r0 = respN;
    procSend(0, ADR_A, 0);
    waitMsgs(n0 + 1);
    repeat (2) @(negedge clk);
    check(logN == n0 + 1, "R5", "load miss message count", 64'(logN - n0), 1);
    checkMsg(n0, 0, ADR_A, LV_S, 0, 0, "R5");
    p2cSend(1, ADR_A, LV_S, 32'hA1A1_0001);
    waitResps(r0 + 1);
    checkLastResp(32'hA1A1_0001, r0 + 1, "R7");
  endtask

  task automatic t_loadHit();
    int n0 = logN;
    procSend(0, ADR_A, 0);
    check(procRespValid == 1, "R2", "hit data valid after accept edge", 64'(procRespValid), 1);
    check(procRespData == 32'hA1A1_0001, "R2", "hit data", 64'(procRespData), 64'h A1A1_0001);
    repeat (3) @(negedge clk);
    check(logN == n0, "R2", "no parent traffic on load hit", 64'(logN - n0), 0);
  endtask

  task automatic t_storeUpgrade();
    int n0 = logN, r0 = respN;
    procSend(1, ADR_A, 32'hB2B2_0002);
    waitMsgs(n0 + 1);
    repeat (2) @(negedge clk);
    check(logN == n0 + 1, "R4", "upgrade sends only a request", 64'(logN - n0), 1);
    checkMsg(n0, 0, ADR_A, LV_M, 0, 0, "R4");
    p2cSend(1, ADR_A, LV_M, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    procSend(0, ADR_A, 0);
    waitResps(r0 + 1);
    checkLastResp(32'hB2B2_0002, r0 + 1, "R4");
  endtask

  task automatic t_storeHitM();
    int n0 = logN, r0 = respN;
    procSend(1, ADR_A, 32'hC3C3_0003);
    repeat (3) @(negedge clk);
    check(logN == n0, "R3", "no parent traffic on store hit in M", 64'(logN - n0), 0);
    procSend(0, ADR_A, 0);
    waitResps(r0 + 1);
    checkLastResp(32'hC3C3_0003, r0 + 1, "R3");
  endtask

  task automatic t_evictDirty();
    int n0 = logN, r0 = respN;
    procSend(0, ADR_B, 0);
    waitMsgs(n0 + 2);
    checkMsg(n0, 1, ADR_A, LV_I, 1, 32'hC3C3_0003, "R6");
    checkMsg(n0 + 1, 0, ADR_B, LV_S, 0, 0, "R6");
    p2cSend(1, ADR_B, LV_S, 32'hD4D4_0004);
    waitResps(r0 + 1);
    checkLastResp(32'hD4D4_0004, r0 + 1, "R7");
  endtask

  task automatic t_evictClean();
    int n0 = logN, r0 = respN;
    procSend(0, ADR_C, 0);
    waitMsgs(n0 + 2);
    checkMsg(n0, 1, ADR_B, LV_I, 0, 0, "R6");
    checkMsg(n0 + 1, 0, ADR_C, LV_S, 0, 0, "R6");
    p2cSend(1, ADR_C, LV_M, 32'hE5E5_0005);
    waitResps(r0 + 1);
    checkLastResp(32'hE5E5_0005, r0 + 1, "R7");
    procSend(1, ADR_C, 32'hF6F6_0006);
    repeat (3) @(negedge clk);
    check(logN == n0 + 2, "R7", "granted M takes store silently", 64'(logN - n0), 2);
  endtask

  task automatic t_downgrade();
    int n0 = logN;
    p2cSend(0, ADR_C, LV_S, 0);
    waitMsgs(n0 + 1);
    checkMsg(n0, 1, ADR_C, LV_S, 1, 32'hF6F6_0006, "R8");
    p2cSend(0, ADR_C, LV_S, 0);
    repeat (3) @(negedge clk);
    check(logN == n0 + 1, "R9", "repeat downgrade dropped", 64'(logN - n0), 1);
    procSend(1, ADR_C, 32'h1717_0007);
    waitMsgs(n0 + 2);
    checkMsg(n0 + 1, 0, ADR_C, LV_M, 0, 0, "R8");
    p2cSend(1, ADR_C, LV_M, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_dnAbsent();
    int n0 = logN, r0 = respN;
    p2cSend(0, ADR_B, LV_I, 0);
    repeat (3) @(negedge clk);
    check(logN == n0, "R9", "downgrade for absent tag dropped", 64'(logN - n0), 0);
    procSend(0, ADR_C, 0);
    waitResps(r0 + 1);
    checkLastResp(32'h1717_0007, r0 + 1, "R9");
    check(logN == n0, "R9", "resident line still hits", 64'(logN - n0), 0);
  endtask

  task automatic t_sameCycle();
    int n0 = logN, r0 = respN;
    @(negedge clk);
    procReqValid = 1; procReqIsStore = 0; procReqAddr = ADR_C;
    p2cValid = 1; p2cIsResp = 0; p2cAddr = ADR_C; p2cState = LV_I;
    #1;
    check(p2cReady == 1, "R10", "downgrade taken first", 64'(p2cReady), 1);
    check(procReqReady == 0, "R10", "processor waits", 64'(procReqReady), 0);
    @(negedge clk);
    p2cValid = 0;
    #1;
    while (!procReqReady) begin @(negedge clk); #1; end
    @(negedge clk);
    procReqValid = 0;
    waitMsgs(n0 + 2);
    checkMsg(n0, 1, ADR_C, LV_I, 1, 32'h1717_0007, "R10");
    checkMsg(n0 + 1, 0, ADR_C, LV_S, 0, 0, "R10");
    p2cSend(1, ADR_C, LV_S, 32'h2828_0008);
    waitResps(r0 + 1);
    checkLastResp(32'h2828_0008, r0 + 1, "R10");
  endtask

  task automatic t_respBlock();
    int n0 = logN, r0 = respN;
    procSend(0, ADR_D, 0);
    waitMsgs(n0 + 1);
    checkMsg(n0, 0, ADR_D, LV_S, 0, 0, "R5");
    @(negedge clk);
    p2cValid = 1; p2cIsResp = 1; p2cAddr = ADR_D; p2cState = LV_S; p2cData = 32'h3939_0009;
    #1;
    while (!p2cReady) begin @(negedge clk); #1; end
    @(negedge clk);
    p2cIsResp = 0; p2cState = LV_I; p2cData = 0;
    #1;
    check(p2cReady == 0, "R10", "downgrade refused in hand-back cycle", 64'(p2cReady), 0);
    @(negedge clk); #1;
    check(p2cReady == 1, "R10", "downgrade accepted next cycle", 64'(p2cReady), 1);
    @(negedge clk);
    p2cValid = 0;
    waitMsgs(n0 + 2);
    checkMsg(n0 + 1, 1, ADR_D, LV_I, 0, 0, "R8");
    checkLastResp(32'h3939_0009, r0 + 1, "R7");
  endtask

  task automatic t_backpressure();
    int n0 = logN, r0 = respN;
    c2pReady = 0;
    procSend(0, ADR_B, 0);
    repeat (4) @(negedge clk);
    #1;
    check(c2pValid == 1 && c2pIsResp == 1, "R12", "eviction held", 64'({c2pValid, c2pIsResp}), 3);
    check(c2pAddr == ADR_C, "R12", "held eviction address", 64'(c2pAddr), 64'(ADR_C));
    check(procReqReady == 0, "R11", "no request while miss outstanding", 64'(procReqReady), 0);
    check(logN == n0, "R12", "nothing taken while not ready", 64'(logN - n0), 0);
    c2pReady = 1;
    waitMsgs(n0 + 2);
    checkMsg(n0, 1, ADR_C, LV_I, 0, 0, "R6");
    checkMsg(n0 + 1, 0, ADR_B, LV_S, 0, 0, "R6");
    procRespReady = 0;
    p2cSend(1, ADR_B, LV_S, 32'h4A4A_000A);
    repeat (4) @(negedge clk);
    #1;
    check(procRespValid == 1, "R12", "load data held", 64'(procRespValid), 1);
    check(procRespData == 32'h4A4A_000A, "R12", "held load data", 64'(procRespData), 64'h4A4A_000A);
    check(procReqReady == 0, "R12", "no request while data waits", 64'(procReqReady), 0);
    procRespReady = 1;
    waitResps(r0 + 1);
    checkLastResp(32'h4A4A_000A, r0 + 1, "R12");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_loadMiss();
    t_loadHit();
    t_storeUpgrade();
    t_storeHitM();
    t_evictDirty();
    t_evictClean();
    t_downgrade();
    t_dnAbsent();
    t_sameCycle();
    t_respBlock();
    t_backpressure();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule